// File: doc/BRIEF.md
# Spread Gated-Clock Deletion Controller

This block takes a free-running bit clock for one channel of a frame-based multiplexer and produces a gated clock enable for it. In each major frame it removes a programmed number of bit-clock pulses, one per selected word. The selected words are spread almost evenly over the frame rather than grouped at its start. The frame generator supplies a strobe on the first bit of every word, a separate strobe on the first bit of word 24, and an end-of-frame strobe that coincides with the word strobe of word 0 of the next frame. A static 10-bit fill count sets how many pulses are removed per frame.

A word counter steps once per word. Its value, with the bit order reversed, is compared against the fill count. While the reversed value is below the fill count, an inhibit is raised and the first bit clock of that word is deleted. A marker travels through a short shift register that is loaded on the word-24 strobe. The marker takes word 29 out of the sequence: no deletion happens in that word, and the counter does not step past it. A frame of 1025 words therefore holds 1024 counted words, and it deletes exactly the fill count.

Top module: `spread_del_ctrl`

## Requirements
- R1: Out of reset `gclk_en` is 1. No pulse is deleted until a word strobe arrives, whatever the fill count.
- R2: `fill_cnt` is a static unsigned 10-bit value. A value of 0 never deletes a pulse.
- R3: Each word has a count c. Take r as c with its bits reversed, so that count bit 9 becomes compare bit 0 and count bit 0 becomes compare bit 9. In a counted word, `inhibit` is 1 exactly when r < `fill_cnt`. It is valid from the cycle after that word's strobe up to and including the cycle of the next strobe.
- R4: A word with `inhibit` high loses exactly one bit-clock pulse. `gclk_en` is 0 for the single cycle after its word strobe. Every other cycle keeps `gclk_en` at 1.
- R5: The count advances by one on every word strobe. The end-of-frame strobe sets it to 0 for word 0, so word w has count w for w < 29 and count w-1 for w > 29.
- R6: A marker is captured on the word-24 strobe and takes effect in the fifth word after that, word 29. In word 29 `inhibit` is 0 and nothing is deleted. The count does not advance when word 29 ends, so word 30 uses the count that word 29 held.
- R7: The end-of-frame strobe clears any marker in flight. A frame that is cut short after word 24 does not affect the next frame.
- R8: A full frame of 1025 words deletes exactly `fill_cnt` pulses. With a fill count of 1023, every counted word except count 1023 deletes.
- R9: Within a full frame, the largest gap between consecutive deletions, measured in counted words, is at most twice the smallest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle pulse on the first bit of every word |
| mark_stb | input | 1 | One-cycle pulse with the word strobe of word 24 |
| eos_stb | input | 1 | End-of-frame pulse, given with the word strobe of word 0 |
| fill_cnt | input | 10 | Static count of pulses to delete per frame |
| gclk_en | output | 1 | Gated clock enable, 0 on a deleted bit |
| inhibit | output | 1 | Delete request for the current word |

## Verification
The checker watches local timing on every cycle. A deleted bit occurs only in the cycle after a word strobe and only while the inhibit is raised. A deleted bit is never followed by a second one unless a new strobe arrives. A zero fill count keeps the clock whole, and the end-of-frame strobe returns the inhibit to its count-zero value. Properties that span a whole frame need the bench's scenarios to show them. These are the bit-reversed selection of each word, the word-29 skip and counter hold, the clearing of a marker by a truncated frame, the exact number of deletions per frame and the evenness of their spacing.

// File: rtl/spread_del_pkg.sv
package spread_del_pkg;

    parameter int unsigned SDC_CNT_W      = 10;
    parameter int unsigned SDC_MARK_DEPTH = 5;

endpackage

// File: rtl/spread_del_word_cnt.sv
module spread_del_word_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_stb,
    input  logic             eos_stb,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eos_stb) begin
            st_d.cnt = '0;
        end else if (word_stb && !hold) begin
            st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/spread_del_marker.sv
module spread_del_marker #(
    parameter int unsigned MARK_DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_stb,
    input  logic mark_stb,
    input  logic eos_stb,
    output logic skip
);

    typedef struct packed {
        logic [MARK_DEPTH-1:0] sr;
        logic                  skip;
    } mark_state_t;

    mark_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eos_stb) begin
            st_d.sr   = '0;
            st_d.skip = 1'b0;
        end else if (word_stb) begin
            st_d.sr   = {st_q.sr[MARK_DEPTH-2:0], mark_stb};
            st_d.skip = st_q.sr[MARK_DEPTH-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign skip = st_q.skip;

endmodule

// File: rtl/spread_del_compare.sv
module spread_del_compare #(
    parameter int unsigned CNT_W = 10
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             below
);

    logic [CNT_W-1:0] rev;

    for (genvar i = 0; i < CNT_W; i++) begin : g_rev
        assign rev[i] = cnt[CNT_W-1-i];
    end

    assign below = (rev < fill_cnt);

endmodule

// File: rtl/spread_del_ctrl.sv
module spread_del_ctrl
    import spread_del_pkg::*;
#(
    parameter int unsigned CNT_W      = SDC_CNT_W,
    parameter int unsigned MARK_DEPTH = SDC_MARK_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_stb,
    input  logic             mark_stb,
    input  logic             eos_stb,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             gclk_en,
    output logic             inhibit
);

    typedef struct packed {
        logic lead;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic             skip;
    logic             below;

    spread_del_marker #(.MARK_DEPTH(MARK_DEPTH)) u_marker (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (word_stb),
        .mark_stb (mark_stb),
        .eos_stb  (eos_stb),
        .skip     (skip)
    );

    spread_del_word_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (word_stb),
        .eos_stb  (eos_stb),
        .hold     (skip),
        .cnt      (cnt)
    );

    spread_del_compare #(.CNT_W(CNT_W)) u_cmp (
        .cnt      (cnt),
        .fill_cnt (fill_cnt),
        .below    (below)
    );

    always_comb begin
        st_d      = st_q;
        st_d.lead = word_stb | eos_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit = below & ~skip;
    assign gclk_en = ~(inhibit & st_q.lead);

endmodule

// File: rtl/spread_del_chk.sv
module spread_del_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_stb,
    input logic             eos_stb,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             gclk_en,
    input logic             inhibit
);

    // R4
    del_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gclk_en |-> $past(word_stb));

    // R4
    del_needs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gclk_en |-> inhibit);

    // R4
    single_del_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gclk_en && !word_stb) |=> gclk_en);

    // R2
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == '0) |-> gclk_en);

    // R5
    eos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eos_stb |=> (inhibit == (fill_cnt != '0)));

endmodule

bind spread_del_ctrl spread_del_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_stb (word_stb),
    .eos_stb  (eos_stb),
    .fill_cnt (fill_cnt),
    .gclk_en  (gclk_en),
    .inhibit  (inhibit)
);

// File: tb/spread_del_ctrl_tb.sv
module spread_del_ctrl_tb;

    localparam int CNT_W = 10;
    localparam int BITS  = 4;
    localparam int WORDS = 1025;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             word_stb = 1'b0;
    logic             mark_stb = 1'b0;
    logic             eos_stb = 1'b0;
    logic [CNT_W-1:0] fill_cnt = '0;
    logic             gclk_en;
    logic             inhibit;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int frame_dels, ndel, last_c, min_gap, max_gap;

    always #4 clk = ~clk;

    spread_del_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_stb (word_stb),
        .mark_stb (mark_stb),
        .eos_stb  (eos_stb),
        .fill_cnt (fill_cnt),
        .gclk_en  (gclk_en),
        .inhibit  (inhibit)
    );

    function automatic int rev10(input int c);
        int r = 0;
        for (int i = 0; i < CNT_W; i++) begin
            if (c[i]) r = r | (1 << (CNT_W - 1 - i));
        end
        return r;
    endfunction

    function automatic int cidx(input int w);
        return (w < 29) ? w : w - 1;
    endfunction

    function automatic int exp_del(input int w, input int f);
        if (w == 29) return 0;
        return (rev10(cidx(w)) < f) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_word(input int w, input string tag);
        int lows = 0;
        int inh1 = 0;
        int e;
        string lbl_i, lbl_d;
        @(negedge clk);
        word_stb = 1'b1;
        mark_stb = (w == 24);
        eos_stb  = (w == 0);
        for (int b = 1; b < BITS; b++) begin
            @(negedge clk);
            if (b == 1) inh1 = inhibit;
            word_stb = 1'b0;
            mark_stb = 1'b0;
            eos_stb  = 1'b0;
            if (!gclk_en) lows++;
        end
        e = exp_del(w, int'(fill_cnt));
        lbl_i = (w == 29 || w == 30) ? "R6" : (tag == "" ? "R3" : tag);
        lbl_d = (w == 29 || w == 30) ? "R6" : (tag == "" ? "R4" : tag);
        chk(inh1 == e, lbl_i, inh1, e);
        chk(lows == e, lbl_d, lows, e);
        if (lows > 0) begin
            if (ndel > 0) begin
                if (cidx(w) - last_c < min_gap) min_gap = cidx(w) - last_c;
                if (cidx(w) - last_c > max_gap) max_gap = cidx(w) - last_c;
            end
            last_c = cidx(w);
            ndel++;
            frame_dels += lows;
        end
    endtask

    task automatic run_frame(input int f, input int nwords, input string tag);
        fill_cnt   = CNT_W'(f);
        frame_dels = 0;
        ndel       = 0;
        last_c     = 0;
        min_gap    = 1 << 20;
        max_gap    = 0;
        for (int w = 0; w < nwords; w++) run_word(w, tag);
        if (nwords == WORDS) begin
            // R8 deletion total per full frame
            chk(frame_dels == f, "R8", frame_dels, f);
            if (f == 0) chk(frame_dels == 0, "R2", frame_dels, 0);
            if (ndel >= 3) begin
                // R9 spacing evenness
                chk(max_gap <= 2 * min_gap, "R9", max_gap, 2 * min_gap);
            end
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5D1C_0A7E);
        fill_cnt = 10'd700;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 no deletion before the first word strobe
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(gclk_en == 1'b1, "R1", gclk_en, 1);
        end

        run_frame(0, WORDS, "");
        run_frame(1023, WORDS, "");
        run_frame(1, WORDS, "");
        run_frame(512, WORDS, "");
        run_frame(3, WORDS, "");
        // R7 truncated frame after the marker load, then a full frame
        run_frame(1023, 27, "");
        run_frame(1023, WORDS, "R5 R7");
        for (int k = 0; k < 4; k++) begin
            run_frame(int'($urandom_range(1022, 2)), WORDS, "");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule